// File: doc/BRIEF.md
# Protected Memory Module Configuration Registers

This block holds the configuration state of an on-chip read-only memory module. It has one 16-bit control register and two 16-bit base-address registers on a simple synchronous register bus. It presents the decoded mode signals to the rest of the module: stopped, bootstrap response, emulation active, address-space field, wait-state count and the 32-bit array base address.

Each field has its own write permission, built from two conditions. Some fields accept a write only while the module is stopped and the register set is unlocked. The wait-state field accepts a write whenever the set is unlocked. The lock flag can be set by software but never cleared. The reset values of the bootstrap and lock flags are build-time parameters. The stop flag loads the inverse of an external pin on the first clock after master reset is released.

A write that is not permitted is dropped silently, and the bus cycle still completes as usual. Bus word offsets are 0 for the control register, 1 for base high and 2 for base low. Control bit positions are STOP 15, BOOT 12, LOCK 11, EMUL 10, ASPC 7:6 and WAIT 5:4. All other control bits are reserved.

Top module: `romcfg_regs`

## Requirements
- R1: After master reset the control word reads STOP equal to the inverse of `stop_pin_i`, BOOT = `BOOT_RST`, LOCK = `LOCK_RST`, and EMUL, ASPC and WAIT zero. Both base registers read zero.
- R2: Reserved control bits 14:13, 9:8 and 3:0 always read zero, and writing ones to them changes nothing.
- R3: A write with bit 11 set sets LOCK. Writing 0 to bit 11 never clears it, and only master reset does.
- R4: BOOT (bit 12) is read-only and keeps its parameter value whatever is written.
- R5: EMUL, ASPC and both base registers take a write only if, before that write, STOP = 1 and LOCK = 0. Otherwise the write is dropped.
- R6: WAIT (bits 5:4) takes a write whenever LOCK = 0 before the write, whatever the value of STOP.
- R7: `boot_en_o` is high while BOOT = 0 and STOP has not gone from 1 to 0 by a software write since master reset. Setting STOP again does not bring it back.
- R8: `emul_act_o` equals EMUL AND STOP. Clearing STOP drops `emul_act_o` but leaves the EMUL bit set.
- R9: Read data appears on `bus_rdata_o` one clock after the read cycle. A read of offset 3 returns zero.
- R10: STOP (bit 15) takes every write in both directions regardless of LOCK. `stopped_o` mirrors it, and `base_addr_o` is {base high, base low}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| stop_pin_i | input | 1 | External data bit sampled for the STOP reset value |
| bus_sel_i | input | 1 | Bus cycle valid |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Word offset |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| stopped_o | output | 1 | STOP state |
| boot_en_o | output | 1 | Respond to bootstrap addresses |
| emul_en_o | output | 1 | EMUL bit |
| emul_act_o | output | 1 | Emulation currently active |
| locked_o | output | 1 | LOCK state |
| aspc_o | output | 2 | Address-space field |
| wait_o | output | 2 | Wait-state count |
| base_addr_o | output | 32 | Array base address |

## Verification
A write is sampled on one rising edge, and every mode output reflects it from that edge on. The bench therefore checks the mode outputs on the falling edge that follows the write cycle. Read data is registered, so it is due exactly one edge after the read cycle. The driver queues the expected word when it issues the read, and a monitor pops and compares it on the next falling edge after a read was seen. The STOP sample from the pin lands on the second edge after reset release plus one, so checks start several cycles after reset.

// File: rtl/romcfg_pkg.sv
package romcfg_pkg;
  localparam int DW        = 16;
  localparam int STOP_B    = 15;
  localparam int BOOT_B    = 12;
  localparam int LOCK_B    = 11;
  localparam int EMUL_B    = 10;
  localparam int ASPC_LSB  = 6;
  localparam int WAIT_LSB  = 4;
  localparam int OFF_CTRL    = 0;
  localparam int OFF_BASE_HI = 1;

  typedef struct packed {
    logic       stop;
    logic       boot;
    logic       lock;
    logic       emul;
    logic [1:0] aspc;
    logic [1:0] waitc;
  } ctrl_t;

  function automatic logic [DW-1:0] pack_ctrl(input ctrl_t c);
    logic [DW-1:0] w;
    w = '0;
    w[STOP_B]                = c.stop;
    w[BOOT_B]                = c.boot;
    w[LOCK_B]                = c.lock;
    w[EMUL_B]                = c.emul;
    w[ASPC_LSB+1:ASPC_LSB]   = c.aspc;
    w[WAIT_LSB+1:WAIT_LSB]   = c.waitc;
    return w;
  endfunction
endpackage

// File: rtl/romcfg_rstsync.sv
module romcfg_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/romcfg_basereg.sv
module romcfg_basereg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic         ok_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;
  logic         en;

  always_comb begin
    en  = we_i & ok_i;
    q_d = en ? wdata_i : q_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)  q_q <= '0;
    else if (en)  q_q <= q_d;
  end

  assign q_o = q_q;

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !ok_i |=> $stable(q_o)); // R5
endmodule

// File: rtl/romcfg_ctrl.sv
module romcfg_ctrl
  import romcfg_pkg::*;
#(
  parameter logic BOOT_RST = 1'b0,
  parameter logic LOCK_RST = 1'b0
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          stop_pin_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output ctrl_t         ctrl_o,
  output logic          prot_ok_o,
  output logic          boot_en_o,
  output logic          emul_act_o
);
  ctrl_t ctrl_q, ctrl_d;
  logic  armed_q, armed_d;
  logic  prot_ok, lock_ok, upd, armed_en;
  logic  unused_wbits;

  assign unused_wbits = ^{wdata_i[14:13], wdata_i[BOOT_B], wdata_i[9:8], wdata_i[3:0]};

  always_comb begin
    prot_ok = ctrl_q.stop & ~ctrl_q.lock;
    lock_ok = ~ctrl_q.lock;
    ctrl_d  = ctrl_q;
    if (wr_i) begin
      ctrl_d.stop = wdata_i[STOP_B];
      if (wdata_i[LOCK_B]) ctrl_d.lock = 1'b1;
      if (prot_ok) begin
        ctrl_d.emul = wdata_i[EMUL_B];
        ctrl_d.aspc = wdata_i[ASPC_LSB+1:ASPC_LSB];
      end
      if (lock_ok) ctrl_d.waitc = wdata_i[WAIT_LSB+1:WAIT_LSB];
    end
    if (init_i) ctrl_d.stop = ~stop_pin_i;
    upd      = wr_i | init_i;
    armed_en = ~init_i & ctrl_q.stop & ~ctrl_d.stop;
    armed_d  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q.stop  <= 1'b1;
      ctrl_q.boot  <= BOOT_RST;
      ctrl_q.lock  <= LOCK_RST;
      ctrl_q.emul  <= 1'b0;
      ctrl_q.aspc  <= 2'b00;
      ctrl_q.waitc <= 2'b00;
    end else if (upd) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)       armed_q <= 1'b1;
    else if (armed_en) armed_q <= armed_d;
  end

  assign ctrl_o     = ctrl_q;
  assign prot_ok_o  = prot_ok;
  assign boot_en_o  = ~ctrl_q.boot & armed_q;
  assign emul_act_o = ctrl_q.emul & ctrl_q.stop;

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    ctrl_o.lock |=> ctrl_o.lock); // R3
  AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !(ctrl_o.stop && !ctrl_o.lock) |=> ($stable(ctrl_o.emul) && $stable(ctrl_o.aspc))); // R5
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    ctrl_o.lock |=> $stable(ctrl_o.waitc)); // R6
  AST_BOOT_GONE: assert property (@(posedge clk) disable iff (!rst_ni)
    !boot_en_o |=> !boot_en_o); // R7
  AST_EMUL_KEEP: assert property (@(posedge clk) disable iff (!rst_ni)
    (!wr_i && !init_i) |=> $stable(ctrl_o.emul)); // R8
endmodule

// File: rtl/romcfg_regs.sv
module romcfg_regs
  import romcfg_pkg::*;
#(
  parameter logic BOOT_RST = 1'b0,
  parameter logic LOCK_RST = 1'b0,
  parameter int   ADDR_W   = 2,
  parameter int   NUM_BASE = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   stop_pin_i,
  input  logic                   bus_sel_i,
  input  logic                   bus_wr_i,
  input  logic [ADDR_W-1:0]      bus_addr_i,
  input  logic [DW-1:0]          bus_wdata_i,
  output logic [DW-1:0]          bus_rdata_o,
  output logic                   stopped_o,
  output logic                   boot_en_o,
  output logic                   emul_en_o,
  output logic                   emul_act_o,
  output logic                   locked_o,
  output logic [1:0]             aspc_o,
  output logic [1:0]             wait_o,
  output logic [NUM_BASE*DW-1:0] base_addr_o
);
  localparam int NUM_REGS = OFF_BASE_HI + NUM_BASE;

  logic          rst_i, init_q;
  ctrl_t         ctrl;
  logic          prot_ok, ctrl_we, rd_fire, rd_hit;
  logic [DW-1:0] base_q [NUM_BASE];
  logic [DW-1:0] rdata_q, rdata_d;

  romcfg_rstsync #(.STAGES(2)) u_rsync (
    .clk(clk), .rst_ni(rst_n), .rst_sync_no(rst_i)
  );

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) init_q <= 1'b1;
    else        init_q <= 1'b0;
  end

  assign ctrl_we = bus_sel_i & bus_wr_i & (bus_addr_i == ADDR_W'(OFF_CTRL));
  assign rd_fire = bus_sel_i & ~bus_wr_i;

  romcfg_ctrl #(.BOOT_RST(BOOT_RST), .LOCK_RST(LOCK_RST)) u_ctrl (
    .clk(clk), .rst_ni(rst_i), .init_i(init_q), .stop_pin_i(stop_pin_i),
    .wr_i(ctrl_we), .wdata_i(bus_wdata_i), .ctrl_o(ctrl),
    .prot_ok_o(prot_ok), .boot_en_o(boot_en_o), .emul_act_o(emul_act_o)
  );

  for (genvar g = 0; g < NUM_BASE; g++) begin : g_base
    logic we;
    assign we = bus_sel_i & bus_wr_i & (bus_addr_i == ADDR_W'(OFF_BASE_HI + g));
    romcfg_basereg #(.W(DW)) u_base (
      .clk(clk), .rst_ni(rst_i), .we_i(we), .ok_i(prot_ok),
      .wdata_i(bus_wdata_i), .q_o(base_q[g])
    );
    assign base_addr_o[(NUM_BASE-g)*DW-1 -: DW] = base_q[g];
  end

  always_comb begin
    rdata_d = '0;
    rd_hit  = 1'b0;
    if (bus_addr_i == ADDR_W'(OFF_CTRL)) begin
      rdata_d = pack_ctrl(ctrl);
      rd_hit  = 1'b1;
    end
    for (int i = 0; i < NUM_BASE; i++) begin
      if (bus_addr_i == ADDR_W'(OFF_BASE_HI + i)) begin
        rdata_d = base_q[i];
        rd_hit  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)       rdata_q <= '0;
    else if (rd_fire) rdata_q <= rdata_d;
  end

  assign bus_rdata_o = rdata_q;
  assign stopped_o   = ctrl.stop;
  assign emul_en_o   = ctrl.emul;
  assign locked_o    = ctrl.lock;
  assign aspc_o      = ctrl.aspc;
  assign wait_o      = ctrl.waitc;

  initial begin
    assert (NUM_REGS <= (1 << ADDR_W));
  end

  AST_RD_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_i)
    (rd_fire && !rd_hit) |=> (bus_rdata_o == '0)); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_i)
    !rd_fire |=> $stable(bus_rdata_o)); // R9
endmodule

// File: tb/romcfg_regs_bench.sv
module romcfg_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n, stop_pin;
  logic        sel, wr;
  logic [1:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        stopped, boot_en, emul_en, emul_act, locked;
  logic [1:0]  aspc, waitc;
  logic [31:0] base;

  int unsigned n_chk = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rvld;

  always #5 clk = ~clk;

  romcfg_regs u_romcfg_regs (
    .clk(clk), .rst_n(rst_n), .stop_pin_i(stop_pin),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .stopped_o(stopped), .boot_en_o(boot_en),
    .emul_en_o(emul_en), .emul_act_o(emul_act), .locked_o(locked),
    .aspc_o(aspc), .wait_o(waitc), .base_addr_o(base)
  );

  always @(posedge clk) rvld <= sel & ~wr;

  always @(negedge clk) begin
    if (rvld) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R9: read data with no expected item, actual %h expected none", rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_fail++;
          $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [15:0] e, input string tag);
    sel = 1'b1; wr = 1'b0; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic do_reset(input logic pin);
    stop_pin = pin;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0; rvld = 1'b0;
    @(negedge clk);
    do_reset(1'b0);
    bus_rd(2'd0, 16'h8000, "R1");
    bus_rd(2'd1, 16'h0000, "R1");
    bus_rd(2'd2, 16'h0000, "R1");
    chk(stopped, 1, "R10");
    chk(boot_en, 1, "R7");
    chk(locked, 0, "R1");

    bus_wr(2'd0, 16'h84F0);
    chk(emul_act, 1, "R8");
    chk({aspc, waitc}, 4'hF, "R5");
    bus_rd(2'd0, 16'h84F0, "R5");
    bus_wr(2'd1, 16'h1234);
    bus_wr(2'd2, 16'hABCD);
    bus_rd(2'd1, 16'h1234, "R5");
    bus_rd(2'd2, 16'hABCD, "R5");
    chk(base, 32'h1234ABCD, "R10");

    bus_wr(2'd0, 16'h0450);
    chk(stopped, 0, "R10");
    chk(emul_act, 0, "R8");
    chk(emul_en, 1, "R8");
    chk(boot_en, 0, "R7");
    bus_rd(2'd0, 16'h0450, "R5");

    bus_wr(2'd1, 16'h5555);
    chk(base, 32'h1234ABCD, "R5");
    bus_wr(2'd0, 16'h0020);
    bus_rd(2'd0, 16'h0460, "R6");

    bus_wr(2'd0, 16'h8460);
    chk(boot_en, 0, "R7");
    chk(emul_act, 1, "R8");
    bus_wr(2'd0, 16'h0460);
    chk(boot_en, 0, "R7");

    bus_wr(2'd0, 16'hF76F);
    bus_rd(2'd0, 16'h8460, "R2");
    bus_rd(2'd0, 16'h8460, "R4");

    bus_wr(2'd0, 16'h8C60);
    chk(locked, 1, "R3");
    bus_wr(2'd0, 16'h8090);
    bus_rd(2'd0, 16'h8C60, "R3");
    bus_wr(2'd2, 16'h0F0F);
    chk(base, 32'h1234ABCD, "R5");
    bus_wr(2'd0, 16'h0000);
    bus_rd(2'd0, 16'h0C60, "R10");
    bus_rd(2'd3, 16'h0000, "R9");

    do_reset(1'b1);
    bus_rd(2'd0, 16'h0000, "R1");
    chk(stopped, 0, "R1");
    chk(locked, 0, "R3");
    chk(boot_en, 1, "R7");
    chk(base, 32'h0, "R1");

    repeat (3) @(negedge clk);
    chk(exp_q.size(), 0, "R9");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule